// File: doc/BRIEF.md
# Vertical Display Start Line Counter

This block places the top edge of an on-screen overlay by counting horizontal sync pulses after each vertical sync pulse. Both sync inputs arrive asynchronously. Each passes through a two-stage synchronizer and is then turned into an active-high pulse by XOR with its polarity bit. The block then looks for the active edge of each pulse.

A detected vertical sync edge first closes the counting window. A fixed number of clocks later, an internal vertical control flag (`vctl`) rises. At that moment the line counter clears and the polarity selection is taken over from the inputs. While the flag is high, every active horizontal sync edge adds one to the line count. The count stops at its maximum value and does not wrap. A one-cycle strobe marks the cycle in which the count takes the programmed start line.

Software sets the polarity bits and the start line directly on input ports. The sync inputs must keep each pulse at least 8 clocks wide. The first horizontal sync edge of a frame must come at least 2 clocks after the vertical sync edge.

Top module: `osd_vstart`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `line_count` is 0, `vctl` is 0 and `disp_start` is 0.
- R2: While `vctl` is 1, each active horizontal sync edge increases `line_count` by exactly one. While `vctl` is 0, no horizontal sync pulse changes `line_count`.
- R3: `pol_sel[0]`=0 makes the rising edge of `hsync_in` the active edge, and `pol_sel[0]`=1 makes its falling edge active. `pol_sel[1]` selects the `vsync_in` edge in the same way.
- R4: Number the first rising clock edge that samples `vsync_in` at its active level as edge 1. Then `vctl` falls at edge 3, and it rises and `line_count` clears to 0 at edge VDLY+3.
- R5: A horizontal sync active edge that occurs between a vertical sync edge and the following rise of `vctl` is not counted.
- R6: `line_count` saturates at 2^CNT_W-1. Further edges leave it there until the next clear.
- R7: `disp_start` is high for exactly one cycle, in the first cycle in which `line_count` holds a newly cleared or incremented value equal to `start_line`. This includes a `start_line` of 0 at the clear.
- R8: A change on `pol_sel` has no effect until `vctl` next rises. The new selection then applies from that edge on.
- R9: Once high, `vctl` stays high and `line_count` holds its value until a new vertical sync edge or a horizontal sync edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_in | input | 1 | Asynchronous horizontal sync |
| vsync_in | input | 1 | Asynchronous vertical sync |
| pol_sel | input | 2 | Bit 0: hsync active low; bit 1: vsync active low |
| start_line | input | CNT_W | Line number at which the display start strobe fires |
| line_count | output | CNT_W | Horizontal sync edges counted since `vctl` rose |
| vctl | output | 1 | Delayed internal vertical control flag (counting enabled) |
| disp_start | output | 1 | One-cycle strobe when the count reaches `start_line` |

## Verification
The bench builds the block with its defaults: CNT_W of 9 and VDLY of 3. The 9-bit counter reaches saturation after 511 edges, which takes only a few thousand cycles of 16-cycle horizontal pulses, so the bench drives the counter into saturation and past it. A 3-cycle delay leaves a blind window of a few clocks after each vertical edge. The bench places a horizontal edge inside that window, at the 2-clock minimum spacing, and probes the exact edge at which `vctl` falls and rises. A behavioural model compares all three outputs every cycle, across both polarities of each sync input.

// File: rtl/osd_vstart.sv
module osd_vstart #(
  parameter int CNT_W = 9,
  parameter int VDLY  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic [1:0]       pol_sel,
  input  logic [CNT_W-1:0] start_line,
  output logic [CNT_W-1:0] line_count,
  output logic             vctl,
  output logic             disp_start
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0]      pol_q;
  logic [2:0]      hs;
  logic [2:0]      vs;
  logic [VDLY-1:0] vpipe;
  logic            upd_q;

  wire h_edge = hs[1] & ~hs[2];
  wire v_edge = vs[1] & ~vs[2];
  wire v_tap  = vpipe[VDLY-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q      <= pol_sel;
      hs         <= '1;
      vs         <= '1;
      vpipe      <= '0;
      vctl       <= 1'b0;
      line_count <= '0;
      upd_q      <= 1'b0;
    end else begin
      hs    <= {hs[1:0], hsync_in ^ pol_q[0]};
      vs    <= {vs[1:0], vsync_in ^ pol_q[1]};
      vpipe <= (vpipe << 1) | VDLY'(v_edge);
      upd_q <= 1'b0;
      if (v_tap) begin
        vctl       <= 1'b1;
        line_count <= '0;
        upd_q      <= 1'b1;
        pol_q      <= pol_sel;
      end else if (v_edge) begin
        vctl <= 1'b0;
      end else if (vctl && h_edge && line_count != CNT_MAX) begin
        line_count <= line_count + CNT_W'(1);
        upd_q      <= 1'b1;
      end
    end
  end

  assign disp_start = upd_q && (line_count == start_line);

endmodule

module osd_vstart_chk #(
  parameter int CNT_W = 9,
  parameter int VDLY  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] start_line,
  input logic [CNT_W-1:0] line_count,
  input logic             vctl,
  input logic             disp_start
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vctl |=> (vctl || $stable(line_count)));

  // R4
  clear_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vctl) |-> line_count == '0);

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vctl |=> (line_count == $past(line_count) ||
              line_count == $past(line_count) + CNT_W'(1) ||
              line_count == '0));

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vctl && line_count == CNT_MAX) |=> (line_count == CNT_MAX || line_count == '0));

  // R7
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_start && $stable(start_line)) |=> !disp_start);

  // R7
  strobe_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_start |-> vctl);

endmodule

bind osd_vstart osd_vstart_chk #(.CNT_W(CNT_W), .VDLY(VDLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_line(start_line),
  .line_count(line_count), .vctl(vctl), .disp_start(disp_start));

// File: tb/test_osd_vstart.sv
module test_osd_vstart;
  localparam int CNT_W = 9;
  localparam int VDLY  = 3;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, hs_raw = 1'b0, vs_raw = 1'b0;
  logic [1:0] pol = 2'b00;
  logic [CNT_W-1:0] sl = 5;
  logic [CNT_W-1:0] line_count;
  logic vctl, disp_start;

  osd_vstart #(.CNT_W(CNT_W), .VDLY(VDLY)) i_osd_vstart (
    .clk(clk), .rst_n(rst_n), .hsync_in(hs_raw), .vsync_in(vs_raw),
    .pol_sel(pol), .start_line(sl), .line_count(line_count),
    .vctl(vctl), .disp_start(disp_start));

  int checks = 0, fails = 0, disp_seen = 0;
  bit hact = 1'b1, vact = 1'b1;

  // behavioural reference model
  bit mh[3], mv[3];
  logic [1:0] m_pol;
  bit m_vctl, m_upd, live = 1'b0;
  int m_cnt;
  bit tapq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      mh = '{1'b1, 1'b1, 1'b1};
      mv = '{1'b1, 1'b1, 1'b1};
      m_pol = pol; m_vctl = 0; m_cnt = 0; m_upd = 0;
      tapq.delete();
      for (int i = 0; i < VDLY; i++) tapq.push_back(1'b0);
      live = 1'b1;
    end else begin
      bit he, ve, tap;
      he = mh[1] && !mh[2];
      ve = mv[1] && !mv[2];
      mh[2] = mh[1]; mh[1] = mh[0]; mh[0] = hs_raw ^ m_pol[0];
      mv[2] = mv[1]; mv[1] = mv[0]; mv[0] = vs_raw ^ m_pol[1];
      tap = tapq.pop_front();
      tapq.push_back(ve);
      m_upd = 0;
      if (tap) begin
        m_vctl = 1; m_cnt = 0; m_upd = 1; m_pol = pol;
      end else if (ve) begin
        m_vctl = 0;
      end else if (m_vctl && he && m_cnt != MAXV) begin
        m_cnt++; m_upd = 1;
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      chk("R2", "line_count vs model", int'(line_count), m_cnt);
      chk("R4", "vctl vs model", int'(vctl), int'(m_vctl));
      chk("R7", "disp_start vs model", int'(disp_start),
          int'(m_upd && m_cnt == int'(sl)));
      if (disp_start) disp_seen++;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hpulse(int w, int g);
    hs_raw = hact; idle(w);
    hs_raw = ~hact; idle(g);
  endtask

  // vertical pulse; htog horizontal toggles inside the blind window
  task automatic vframe(int htog);
    vs_raw = vact; idle(2);
    if (htog > 0) hs_raw = ~hs_raw;
    idle(8);
    if (htog > 1) hs_raw = ~hs_raw;
    vs_raw = ~vact; idle(12);
  endtask

  task automatic vframe_timed();
    int was;
    was = int'(vctl);
    vs_raw = vact; idle(2);
    chk("R4", "vctl at edge 2", int'(vctl), was);
    idle(1);
    chk("R4", "vctl at edge 3", int'(vctl), 0);
    idle(VDLY - 1);
    chk("R4", "vctl at edge VDLY+2", int'(vctl), 0);
    idle(1);
    chk("R4", "vctl at edge VDLY+3", int'(vctl), 1);
    chk("R4", "cleared count at edge VDLY+3", int'(line_count), 0);
    idle(7 - VDLY);
    vs_raw = ~vact; idle(12);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(4);
    chk("R1", "reset line_count", int'(line_count), 0);
    chk("R1", "reset vctl", int'(vctl), 0);
    chk("R1", "reset disp_start", int'(disp_start), 0);
    rst_n = 1'b1; idle(5);

    for (int i = 0; i < 3; i++) hpulse(9, 9);
    chk("R2", "no count before vctl", int'(line_count), 0);

    vframe(2);
    chk("R5", "edge in blind window", int'(line_count), 0);
    chk("R4", "vctl after frame", int'(vctl), 1);

    vframe_timed();
    disp_seen = 0;
    for (int i = 0; i < 7; i++) hpulse(9, 9);
    chk("R2", "seven lines", int'(line_count), 7);
    chk("R7", "strobe count at line 5", disp_seen, 1);
    idle(30);
    chk("R9", "hold between pulses", int'(line_count), 7);
    chk("R9", "vctl held", int'(vctl), 1);

    pol = 2'b01;
    hpulse(9, 9); hpulse(9, 9);
    chk("R8", "old hsync polarity still used", int'(line_count), 9);
    vframe(1);
    hact = 1'b0;
    chk("R8", "new polarity clean after latch", int'(line_count), 0);
    for (int i = 0; i < 4; i++) hpulse(9, 9);
    chk("R3", "falling hsync edges counted", int'(line_count), 4);

    sl = 300; disp_seen = 0;
    vframe(0);
    for (int i = 0; i < MAXV + 9; i++) hpulse(8, 8);
    chk("R6", "saturated count", int'(line_count), MAXV);
    chk("R7", "single strobe at line 300", disp_seen, 1);

    sl = 0; idle(2); disp_seen = 0;
    vframe(0);
    chk("R7", "strobe at clear for line 0", disp_seen, 1);

    rst_n = 1'b0; pol = 2'b11; hs_raw = 1'b1; vs_raw = 1'b1;
    hact = 1'b0; vact = 1'b0; sl = 2;
    idle(3);
    chk("R1", "second reset vctl", int'(vctl), 0);
    rst_n = 1'b1; idle(5);
    vframe_timed();
    chk("R3", "active-low vsync opens window", int'(vctl), 1);
    disp_seen = 0;
    for (int i = 0; i < 3; i++) hpulse(9, 9);
    chk("R3", "active-low lines", int'(line_count), 3);
    chk("R7", "strobe at line 2", disp_seen, 1);

    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule